// File: doc/BRIEF.md
# Dual Stack Pointer Bank

This block keeps the two stack pointers of a processor with a supervisor mode and a user mode. The two physical registers are named by role, not by mode. One is the active pointer and the other is the inactive pointer. A role-select flop says which physical register is active at any time. When the supervisor bit changes, that flop toggles and the roles swap. No data is copied between the registers.

The processor datapath sees only the active pointer. It reads it combinationally and writes it with a write enable. A debug port reaches both registers by a one-bit role index (active or other), with no translation by mode. A debug tool works out which role holds the supervisor pointer and which holds the user pointer from the supervisor bit. With the bit at 1, the active register holds the supervisor pointer and the other register holds the user pointer. With the bit at 0 the two are the other way round.

Top module: `dual_sp_bank`

## Requirements
- R1: A synchronous reset clears both registers to zero and records the tracked mode as supervisor. If `sup_i` is held at 1 after reset, no role swap takes place.
- R2: `dp_sp_o` always shows the active register, combinationally.
- R3: At a clock edge where `sup_i` differs from the tracked mode, the roles swap. After that edge, the other register returns the value the active register had before the edge, and the active register returns the previous other value.
- R4: When `dp_we_i` is 1, `dp_wdata_i` is written to the active register. The new value shows on `dp_sp_o` after that edge.
- R5: The debug index `dbg_idx_i` selects a role: 0 is the active register and 1 is the other register. `dbg_rdata_o` shows the selected register combinationally. When `dbg_we_i` is 1, `dbg_wdata_i` is written to the selected register at the edge.
- R6: If a datapath write and a debug write target the same register in one cycle, the debug data is stored. If they target different registers, both are stored.
- R7: In a cycle with no write and no mode change, both registers keep their values.
- R8: A write in a cycle that also changes the mode goes to the roles that held before that edge. For example, a datapath write lands in the register that is the other one after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_i | input | 1 | Supervisor mode bit |
| dp_we_i | input | 1 | Datapath write enable for the active pointer |
| dp_wdata_i | input | SP_W | Datapath write data |
| dp_sp_o | output | SP_W | Active pointer value |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_idx_i | input | 1 | Debug role index, 0 = active, 1 = other |
| dbg_wdata_i | input | SP_W | Debug write data |
| dbg_rdata_o | output | SP_W | Debug read data for the selected role |

## Verification
The checker tests a set of rules at every edge:
- the swap on a mode change with no writes;
- the datapath write landing in the active register;
- debug writes to either role;
- debug priority in a conflict;
- the redirection of writes in a mode-change cycle;
- holding when idle.

The bench's scenarios follow the supervisor and user meanings across several swaps against a model kept by mode. Only these scenarios show the reset state and the combinational debug read of both roles. They also show that a pointer written in one mode comes back unchanged after a return to that mode.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;

    localparam int SP_W_DEF = 32;
    localparam int NUM_SP   = 2;

    typedef enum logic {
        IDX_ACTIVE = 1'b0,
        IDX_OTHER  = 1'b1
    } sp_idx_e;

    // Physical register number addressed by a role index, given the active select.
    function automatic logic phys_of(input logic act_sel, input sp_idx_e idx);
        return (idx == IDX_OTHER) ? ~act_sel : act_sel;
    endfunction

endpackage

// File: rtl/sp_role_ctrl.sv
module sp_role_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic sup_i,
    output logic mode_q,
    output logic act_sel_q
);
    // R3: a mode change only toggles which physical register plays the active role.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= 1'b1;   // R1: reset is supervisor mode
            act_sel_q <= 1'b0;
        end else if (sup_i != mode_q) begin
            mode_q    <= sup_i;
            act_sel_q <= ~act_sel_q;
        end
    end
endmodule

// File: rtl/sp_wr_arb.sv
module sp_wr_arb
    import sp_bank_pkg::*;
#(
    parameter int SP_W = SP_W_DEF
) (
    input  logic                         act_sel,
    input  logic                         dp_we,
    input  logic [SP_W-1:0]              dp_wdata,
    input  logic                         dbg_we,
    input  sp_idx_e                      dbg_idx,
    input  logic [SP_W-1:0]              dbg_wdata,
    output logic [NUM_SP-1:0]            we,
    output logic [NUM_SP-1:0][SP_W-1:0]  wdata
);
    logic dbg_phys;
    assign dbg_phys = phys_of(act_sel, dbg_idx);

    for (genvar i = 0; i < NUM_SP; i++) begin : g_port
        logic dp_hit, dbg_hit;
        always_comb begin
            dp_hit   = dp_we  && (act_sel  == 1'(i));
            dbg_hit  = dbg_we && (dbg_phys == 1'(i));
            we[i]    = dp_hit | dbg_hit;
            // R6: debug data wins on a shared target
            wdata[i] = dbg_hit ? dbg_wdata : dp_wdata;
        end
    end
endmodule

// File: rtl/sp_reg.sv
module sp_reg #(
    parameter int SP_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SP_W-1:0] wdata,
    output logic [SP_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/dual_sp_bank.sv
module dual_sp_bank
    import sp_bank_pkg::*;
#(
    parameter int SP_W = SP_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sup_i,
    input  logic            dp_we_i,
    input  logic [SP_W-1:0] dp_wdata_i,
    output logic [SP_W-1:0] dp_sp_o,
    input  logic            dbg_we_i,
    input  logic            dbg_idx_i,
    input  logic [SP_W-1:0] dbg_wdata_i,
    output logic [SP_W-1:0] dbg_rdata_o
);
    logic                         mode_q;
    logic                         act_sel;
    logic [NUM_SP-1:0]            reg_we;
    logic [NUM_SP-1:0][SP_W-1:0]  reg_wdata;
    logic [NUM_SP-1:0][SP_W-1:0]  reg_q;
    logic [SP_W-1:0]              act_val;
    logic [SP_W-1:0]              oth_val;
    sp_idx_e                      dbg_idx;

    assign dbg_idx = sp_idx_e'(dbg_idx_i);

    sp_role_ctrl u_role (
        .clk       (clk),
        .rst       (rst),
        .sup_i     (sup_i),
        .mode_q    (mode_q),
        .act_sel_q (act_sel)
    );

    sp_wr_arb #(.SP_W(SP_W)) u_arb (
        .act_sel   (act_sel),
        .dp_we     (dp_we_i),
        .dp_wdata  (dp_wdata_i),
        .dbg_we    (dbg_we_i),
        .dbg_idx   (dbg_idx),
        .dbg_wdata (dbg_wdata_i),
        .we        (reg_we),
        .wdata     (reg_wdata)
    );

    for (genvar i = 0; i < NUM_SP; i++) begin : g_sp
        sp_reg #(.SP_W(SP_W)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (reg_we[i]),
            .wdata (reg_wdata[i]),
            .q     (reg_q[i])
        );
    end

    assign act_val     = reg_q[act_sel];
    assign oth_val     = reg_q[~act_sel];
    assign dp_sp_o     = act_val;                                   // R2
    assign dbg_rdata_o = (dbg_idx == IDX_OTHER) ? oth_val : act_val; // R5
endmodule

// File: rtl/sp_bank_chk.sv
module sp_bank_chk #(
    parameter int SP_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            sup_i,
    input logic            dp_we_i,
    input logic [SP_W-1:0] dp_wdata_i,
    input logic            dbg_we_i,
    input logic            dbg_idx_i,
    input logic [SP_W-1:0] dbg_wdata_i,
    input logic [SP_W-1:0] dp_sp_o,
    input logic            mode_q,
    input logic [SP_W-1:0] act_val,
    input logic [SP_W-1:0] oth_val
);
    p_swap_r3: assert property (@(posedge clk) disable iff (rst)
        (sup_i != mode_q && !dp_we_i && !dbg_we_i)
        |=> (oth_val == $past(act_val) && act_val == $past(oth_val)));

    p_dp_write_r4: assert property (@(posedge clk) disable iff (rst)
        (sup_i == mode_q && dp_we_i && !dbg_we_i)
        |=> (dp_sp_o == $past(dp_wdata_i)));

    p_dbg_active_r5: assert property (@(posedge clk) disable iff (rst)
        (sup_i == mode_q && dbg_we_i && !dbg_idx_i)
        |=> (act_val == $past(dbg_wdata_i)));

    p_dbg_other_r5: assert property (@(posedge clk) disable iff (rst)
        (sup_i == mode_q && dbg_we_i && dbg_idx_i && !dp_we_i)
        |=> (oth_val == $past(dbg_wdata_i)));

    p_dbg_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (sup_i == mode_q && dbg_we_i && !dbg_idx_i && dp_we_i)
        |=> (dp_sp_o == $past(dbg_wdata_i)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sup_i == mode_q && !dp_we_i && !dbg_we_i)
        |=> ($stable(act_val) && $stable(oth_val)));

    p_old_role_r8: assert property (@(posedge clk) disable iff (rst)
        (sup_i != mode_q && dp_we_i && !dbg_we_i)
        |=> (oth_val == $past(dp_wdata_i)));
endmodule

bind dual_sp_bank sp_bank_chk #(.SP_W(SP_W)) u_chk (.*);

// File: tb/dual_sp_bank_tb.sv
module dual_sp_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         sup_i;
    logic         dp_we_i;
    logic [W-1:0] dp_wdata_i;
    logic [W-1:0] dp_sp_o;
    logic         dbg_we_i;
    logic         dbg_idx_i;
    logic [W-1:0] dbg_wdata_i;
    logic [W-1:0] dbg_rdata_o;

    int n_run  = 0;
    int n_fail = 0;

    // Model kept by meaning: supervisor and user pointer, plus mode.
    logic [W-1:0] m_sup, m_usr;
    logic         m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_sp_bank #(.SP_W(W)) dut_i (.*);

    function automatic logic [W-1:0] exp_act();
        return m_mode ? m_sup : m_usr;
    endfunction
    function automatic logic [W-1:0] exp_oth();
        return m_mode ? m_usr : m_sup;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drives one cycle and updates the model by mode meaning.
    task automatic step(input logic dpw, input logic [W-1:0] dpd,
                        input logic dbw, input logic dbi, input logic [W-1:0] dbd,
                        input logic sup);
        @(negedge clk);
        dp_we_i = dpw; dp_wdata_i = dpd;
        dbg_we_i = dbw; dbg_idx_i = dbi; dbg_wdata_i = dbd;
        sup_i = sup;
        @(posedge clk);
        if (dpw) begin
            if (m_mode) m_sup = dpd; else m_usr = dpd;
        end
        if (dbw) begin
            if ((dbi == 1'b0) ? m_mode : !m_mode) m_sup = dbd; else m_usr = dbd;
        end
        m_mode = sup;
        #1;
        dp_we_i = 1'b0; dbg_we_i = 1'b0;
    endtask

    task automatic check_all(input string req);
        chk({req, " dp_sp_o"}, dp_sp_o, exp_act());
        dbg_idx_i = 1'b0; #1;
        chk({req, " dbg active"}, dbg_rdata_o, exp_act());
        dbg_idx_i = 1'b1; #1;
        chk({req, " dbg other"}, dbg_rdata_o, exp_oth());
    endtask

    task automatic t_reset();
        rst = 1'b1; sup_i = 1'b1; dp_we_i = 0; dbg_we_i = 0; dbg_idx_i = 0;
        dp_wdata_i = '0; dbg_wdata_i = '0;
        m_sup = '0; m_usr = '0; m_mode = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check_all("R1 reset");
        step(0, '0, 0, 0, '0, 1);       // R1: held supervisor, no swap
        check_all("R1 no swap");
    endtask

    task automatic t_dp_write();
        step(1, 32'h0000_8000, 0, 0, '0, 1);
        check_all("R4 dp write sup");
        chk("R2 active", dp_sp_o, 32'h0000_8000);
    endtask

    task automatic t_mode_swap();
        logic [W-1:0] prev;
        prev = dp_sp_o;
        step(0, '0, 0, 0, '0, 0);
        dbg_idx_i = 1'b1; #1;
        chk("R3 other after swap", dbg_rdata_o, prev);
        check_all("R3 swap to user");
        step(1, 32'h0000_1F00, 0, 0, '0, 0);
        check_all("R4 dp write usr");
        step(0, '0, 0, 0, '0, 1);
        chk("R3 sup pointer back", dp_sp_o, 32'h0000_8000);
        check_all("R3 swap to sup");
    endtask

    task automatic t_dbg_access();
        step(0, '0, 1, 1, 32'hCAFE_0010, 1);
        check_all("R5 dbg write other");
        step(0, '0, 1, 0, 32'hBEEF_0020, 1);
        check_all("R5 dbg write active");
    endtask

    task automatic t_conflict();
        step(1, 32'h1111_1111, 1, 0, 32'h2222_2222, 1);
        chk("R6 dbg wins", dp_sp_o, 32'h2222_2222);
        check_all("R6 same target");
        step(1, 32'h3333_3333, 1, 1, 32'h4444_4444, 1);
        check_all("R6 split targets");
    endtask

    task automatic t_hold();
        step(0, 32'hFFFF_FFFF, 0, 1, 32'hFFFF_FFFF, 1);
        step(0, 32'hFFFF_FFFF, 0, 0, 32'hFFFF_FFFF, 1);
        check_all("R7 hold");
    endtask

    task automatic t_write_on_swap();
        step(1, 32'h5555_0000, 0, 0, '0, 0);
        dbg_idx_i = 1'b1; #1;
        chk("R8 dp write to old role", dbg_rdata_o, 32'h5555_0000);
        check_all("R8 dp on swap");
        step(0, '0, 1, 1, 32'h6666_0000, 1);
        chk("R8 dbg other to old role", dp_sp_o, 32'h6666_0000);
        check_all("R8 dbg on swap");
    endtask

    initial begin
        t_reset();
        t_dp_write();
        t_mode_swap();
        t_dbg_access();
        t_conflict();
        t_hold();
        t_write_on_swap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule